// File: doc/BRIEF.md
# Reconfigurable Region Isolation Controller

This block sits between static logic and one reconfigurable region. While the region is reprogrammed, it holds the region isolated and, if asked, in reset. A host drives it through a small word-addressed 32-bit register bus. To isolate the region, the host writes a request to close it off. The controller raises the isolation output and waits for the region to acknowledge, or for a fixed number of cycles to pass. It then reports that the freeze has completed.

With the region held, the host may raise the region reset. After reprogramming, the host requests a release. The controller drops the reset, keeps isolation up for a short settling interval, and then reports the region open again. Requests that do not fit the current state, or that combine several operations in one write, change nothing. Instead they leave a nonzero code in an error register, which the host clears by writing 1.

Register byte offsets are: status 0, control 4, error code 8, version 12. Every other offset reads as 0.

Top module: `pr_iso_ctrl`

## Requirements
- R1: After reset the status register reads 2 (bit 1 "open" set, bit 0 "frozen" clear). Control reads 0, the error code reads 0, and both `iso_freeze` and `iso_reset` are low.
- R2: Offset 12 reads the constant 2. Any offset other than 0, 4, 8 or 12, including unaligned ones, reads 0.
- R3: Writes to offsets 0 and 12 leave both registers unchanged.
- R4: Writing control value 1 (bit 0 = freeze) while open raises `iso_freeze` after that write edge. Status stays 2 until the first edge that samples `iso_ack` high; at that edge status becomes 1.
- R5: Without an acknowledge, status becomes 1 at the 8th clock edge after the freeze write edge. Until then it reads 2.
- R6: Writing control value 2 (bit 1 = region reset) while frozen raises `iso_reset`. A later control write of 0 lowers it.
- R7: Writing control value 4 (bit 2 = release) while frozen lowers `iso_reset` after that edge. `iso_freeze` stays high until the 2nd edge after the write, and status becomes 2 at that same edge.
- R8: An illegal control write changes neither the state nor the control register. It latches an error code: 1 when more than one of bits 2:0 is set, 2 for a freeze while not open, 3 for a release while not frozen, and 4 for a region reset while not frozen.
- R9: Writing a value with bit 0 set to offset 8 clears the error code. A write there with bit 0 clear leaves it unchanged.
- R10: Control (offset 4) reads back bits 2:0 of the last accepted control write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| iso_freeze | output | 1 | Isolation of the region, high while not open |
| iso_reset | output | 1 | Reset to the region |
| iso_ack | input | 1 | Region acknowledges isolation |

## Verification
Read data is combinational, so each read is sampled one time step after the address is set. Register, error-code and output changes land on the write edge and are checked at the following falling edge. Completion of a freeze without acknowledge is due at the 8th edge after the write edge, so the bench confirms status still reads 2 after the 7th edge and 1 after the 8th. An acknowledge raised after the write edge completes the freeze at the very next edge. A release drops isolation and sets status at the 2nd edge, and the bench checks it after both the 1st and the 2nd.

// File: rtl/pr_iso_pkg.sv
package pr_iso_pkg;

  typedef enum logic [1:0] {
    ST_OPEN    = 2'd0,
    ST_CLOSING = 2'd1,
    ST_SEALED  = 2'd2,
    ST_OPENING = 2'd3
  } iso_state_e;

  localparam int unsigned OFS_STATUS  = 0;
  localparam int unsigned OFS_CTRL    = 4;
  localparam int unsigned OFS_ERR     = 8;
  localparam int unsigned OFS_VERSION = 12;
  localparam int unsigned VERSION_VAL = 2;

  localparam int unsigned ERR_W = 3;
  localparam logic [ERR_W-1:0] ERR_NONE  = 3'd0;
  localparam logic [ERR_W-1:0] ERR_MULTI = 3'd1;
  localparam logic [ERR_W-1:0] ERR_FRZ   = 3'd2;
  localparam logic [ERR_W-1:0] ERR_REL   = 3'd3;
  localparam logic [ERR_W-1:0] ERR_RST   = 3'd4;

  // Control bit positions
  localparam int unsigned CB_FREEZE  = 0;
  localparam int unsigned CB_RESET   = 1;
  localparam int unsigned CB_RELEASE = 2;

  // Classify a control request against the current stable state.
  function automatic logic [ERR_W-1:0] classify_req(input logic [2:0] req,
                                                     input logic is_open,
                                                     input logic is_sealed);
    logic [ERR_W-1:0] code;
    if ($countones(req) > 1)                     code = ERR_MULTI;
    else if (req[CB_FREEZE]  && !is_open)        code = ERR_FRZ;
    else if (req[CB_RELEASE] && !is_sealed)      code = ERR_REL;
    else if (req[CB_RESET]   && !is_sealed)      code = ERR_RST;
    else                                         code = ERR_NONE;
    return code;
  endfunction

  // Last count value of a wait of n cycles starting at zero.
  function automatic int unsigned last_count(input int unsigned n);
    return (n == 0) ? 0 : n - 1;
  endfunction

endpackage

// File: rtl/pr_iso_fsm.sv
module pr_iso_fsm
  import pr_iso_pkg::*;
#(
  parameter int unsigned HOLD_CYCLES    = 8,
  parameter int unsigned RELEASE_CYCLES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       freeze_go,
  input  logic       release_go,
  input  logic       region_ack,
  output logic       st_open,
  output logic       st_sealed,
  output logic [1:0] stat_bits,
  output logic       region_iso
);

  localparam int unsigned MAXC  = (HOLD_CYCLES > RELEASE_CYCLES) ? HOLD_CYCLES : RELEASE_CYCLES;
  localparam int unsigned CNT_W = (MAXC < 2) ? 1 : $clog2(MAXC);
  localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(last_count(HOLD_CYCLES));
  localparam logic [CNT_W-1:0] REL_LAST  = CNT_W'(last_count(RELEASE_CYCLES));

  iso_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [1:0]       stat_q;   // {open_done, frozen_done}

  // Named internal events
  logic close_done;
  logic open_done;

  assign close_done = (state_q == ST_CLOSING) && (region_ack || cnt_q == HOLD_LAST);
  assign open_done  = (state_q == ST_OPENING) && (cnt_q == REL_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OPEN;
      cnt_q   <= '0;
      stat_q  <= 2'b10;
    end else begin
      unique case (state_q)
        ST_OPEN: if (freeze_go) begin
          state_q <= ST_CLOSING;
          cnt_q   <= '0;
        end
        ST_CLOSING: if (close_done) begin
          state_q <= ST_SEALED;
          stat_q  <= 2'b01;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
        ST_SEALED: if (release_go) begin
          state_q <= ST_OPENING;
          cnt_q   <= '0;
        end
        ST_OPENING: if (open_done) begin
          state_q <= ST_OPEN;
          stat_q  <= 2'b10;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
        default: state_q <= ST_OPEN;
      endcase
    end
  end

  assign st_open    = (state_q == ST_OPEN);
  assign st_sealed  = (state_q == ST_SEALED);
  assign stat_bits  = stat_q;
  assign region_iso = (state_q != ST_OPEN);

  // R1: exactly one completion flag is reported at any time
  p_status_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(stat_q) == 1);

  // R4: an accepted freeze isolates the region on the next cycle
  p_go_isolates_r4: assert property (@(posedge clk) disable iff (!rst_n)
    freeze_go |=> region_iso);

  // R4: frozen status is only reported with isolation up
  p_frozen_isolated_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stat_q[0] |-> region_iso);

  // R5: the cycle limit always completes the freeze
  p_timeout_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CLOSING && cnt_q == HOLD_LAST) |=> stat_q == 2'b01);

  // R7: completing a release reports open status
  p_release_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(region_iso) |-> stat_q == 2'b10);

endmodule

// File: rtl/pr_iso_regs.sv
module pr_iso_regs
  import pr_iso_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              st_open,
  input  logic              st_sealed,
  input  logic [1:0]        stat_bits,
  output logic [DATA_W-1:0] rdata,
  output logic              freeze_go,
  output logic              release_go,
  output logic [2:0]        ctrl_bits
);

  logic [2:0]       ctrl_q;
  logic [ERR_W-1:0] err_q;

  logic             wr_ctrl;
  logic             wr_err;
  logic [2:0]       req;
  logic [ERR_W-1:0] req_code;
  logic             illegal_ev;
  logic             accept_ev;

  assign wr_ctrl    = wr_en && (addr == ADDR_W'(OFS_CTRL));
  assign wr_err     = wr_en && (addr == ADDR_W'(OFS_ERR));
  assign req        = wdata[2:0];
  assign req_code   = classify_req(req, st_open, st_sealed);
  assign illegal_ev = wr_ctrl && (req_code != ERR_NONE);
  assign accept_ev  = wr_ctrl && (req_code == ERR_NONE);
  assign freeze_go  = accept_ev && req[CB_FREEZE];
  assign release_go = accept_ev && req[CB_RELEASE];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      err_q  <= ERR_NONE;
    end else begin
      if (accept_ev) ctrl_q <= req;
      if (illegal_ev)               err_q <= req_code;
      else if (wr_err && wdata[0])  err_q <= ERR_NONE;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(OFS_STATUS))       rdata[1:0]       = stat_bits;
    else if (addr == ADDR_W'(OFS_CTRL))    rdata[2:0]       = ctrl_q;
    else if (addr == ADDR_W'(OFS_ERR))     rdata[ERR_W-1:0] = err_q;
    else if (addr == ADDR_W'(OFS_VERSION)) rdata            = DATA_W'(VERSION_VAL);
  end

  assign ctrl_bits = ctrl_q;

  // R8: an illegal request records its code
  p_err_latch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_ev |=> err_q == $past(req_code));

  // R8: an illegal request leaves control untouched
  p_err_noeffect_r8: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_ev |=> $stable(ctrl_q));

  // R8: an illegal request starts no operation
  p_err_no_go_r8: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_ev |-> !freeze_go && !release_go);

  // R9: writing 1 to the error register clears it
  p_err_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_err && wdata[0]) |=> err_q == ERR_NONE);

endmodule

// File: rtl/pr_iso_ctrl.sv
module pr_iso_ctrl
  import pr_iso_pkg::*;
#(
  parameter int unsigned DATA_W         = 32,
  parameter int unsigned ADDR_W         = 5,
  parameter int unsigned HOLD_CYCLES    = 8,
  parameter int unsigned RELEASE_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              iso_freeze,
  output logic              iso_reset,
  input  logic              iso_ack
);

  logic       freeze_go;
  logic       release_go;
  logic       st_open;
  logic       st_sealed;
  logic [1:0] stat_bits;
  logic [2:0] ctrl_bits;

  pr_iso_regs #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (bus_wr),
    .addr      (bus_addr),
    .wdata     (bus_wdata),
    .st_open   (st_open),
    .st_sealed (st_sealed),
    .stat_bits (stat_bits),
    .rdata     (bus_rdata),
    .freeze_go (freeze_go),
    .release_go(release_go),
    .ctrl_bits (ctrl_bits)
  );

  pr_iso_fsm #(
    .HOLD_CYCLES   (HOLD_CYCLES),
    .RELEASE_CYCLES(RELEASE_CYCLES)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .freeze_go (freeze_go),
    .release_go(release_go),
    .region_ack(iso_ack),
    .st_open   (st_open),
    .st_sealed (st_sealed),
    .stat_bits (stat_bits),
    .region_iso(iso_freeze)
  );

  assign iso_reset = ctrl_bits[CB_RESET];

  // R6: the region reset is only driven while fully frozen
  p_reset_only_sealed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    iso_reset |-> (st_sealed && iso_freeze));

  // R7: reset is gone before isolation is released
  p_reset_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(iso_freeze) |-> !iso_reset);

endmodule

// File: tb/pr_iso_ctrl_tb.sv
module pr_iso_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        iso_freeze;
  logic        iso_reset;
  logic        iso_ack = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  pr_iso_ctrl u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .iso_freeze(iso_freeze),
    .iso_reset(iso_reset),
    .iso_ack  (iso_ack)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Drive at a falling edge, commit at the next rising edge, return at the next falling edge.
  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic rd_check(input string tag, input logic [4:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(tag, v, exp);
  endtask

  task automatic t_reset_state();
    rd_check("R1 status", 5'd0, 32'd2);
    rd_check("R1 control", 5'd4, 32'd0);
    rd_check("R1 error", 5'd8, 32'd0);
    check("R1 iso_freeze", {31'd0, iso_freeze}, 32'd0);
    check("R1 iso_reset", {31'd0, iso_reset}, 32'd0);
  endtask

  task automatic t_map();
    rd_check("R2 version", 5'd12, 32'd2);
    rd_check("R2 offset16", 5'd16, 32'd0);
    rd_check("R2 offset28", 5'd28, 32'd0);
    rd_check("R2 unaligned2", 5'd2, 32'd0);
    rd_check("R2 unaligned13", 5'd13, 32'd0);
  endtask

  task automatic t_readonly();
    wr(5'd0, 32'hFFFF_FFFF);
    wr(5'd12, 32'h0000_00A5);
    rd_check("R3 status unchanged", 5'd0, 32'd2);
    rd_check("R3 version unchanged", 5'd12, 32'd2);
    check("R3 no isolation", {31'd0, iso_freeze}, 32'd0);
  endtask

  task automatic t_illegal_open();
    wr(5'd4, 32'd2);
    rd_check("R8 reset while open code", 5'd8, 32'd4);
    rd_check("R8 reset while open ctrl", 5'd4, 32'd0);
    check("R8 reset while open pin", {31'd0, iso_reset}, 32'd0);
    wr(5'd8, 32'd2);
    rd_check("R9 write without bit0 keeps", 5'd8, 32'd4);
    wr(5'd8, 32'd1);
    rd_check("R9 clear", 5'd8, 32'd0);
    wr(5'd4, 32'd4);
    rd_check("R8 release while open code", 5'd8, 32'd3);
    check("R8 release while open iso", {31'd0, iso_freeze}, 32'd0);
    wr(5'd4, 32'd5);
    rd_check("R8 multi code", 5'd8, 32'd1);
    check("R8 multi no iso", {31'd0, iso_freeze}, 32'd0);
    rd_check("R8 multi status", 5'd0, 32'd2);
    wr(5'd8, 32'd1);
    rd_check("R9 clear again", 5'd8, 32'd0);
  endtask

  task automatic t_freeze_timeout();
    wr(5'd4, 32'd1);
    check("R5 iso raised", {31'd0, iso_freeze}, 32'd1);
    rd_check("R10 ctrl readback freeze", 5'd4, 32'd1);
    repeat (7) @(negedge clk);
    rd_check("R5 status after 7 edges", 5'd0, 32'd2);
    @(negedge clk);
    rd_check("R5 status after 8 edges", 5'd0, 32'd1);
  endtask

  task automatic t_sealed_ops();
    wr(5'd4, 32'd1);
    rd_check("R8 freeze while frozen code", 5'd8, 32'd2);
    rd_check("R8 freeze while frozen ctrl", 5'd4, 32'd1);
    wr(5'd8, 32'd1);
    wr(5'd4, 32'd2);
    check("R6 reset raised", {31'd0, iso_reset}, 32'd1);
    rd_check("R10 ctrl readback reset", 5'd4, 32'd2);
    wr(5'd4, 32'd0);
    check("R6 reset dropped", {31'd0, iso_reset}, 32'd0);
    check("R6 still isolated", {31'd0, iso_freeze}, 32'd1);
    wr(5'd4, 32'd2);
    check("R6 reset raised again", {31'd0, iso_reset}, 32'd1);
  endtask

  task automatic t_release();
    wr(5'd4, 32'd4);
    check("R7 reset low after write", {31'd0, iso_reset}, 32'd0);
    check("R7 iso held after write", {31'd0, iso_freeze}, 32'd1);
    rd_check("R7 status frozen after write", 5'd0, 32'd1);
    @(negedge clk);
    check("R7 iso held after edge 1", {31'd0, iso_freeze}, 32'd1);
    @(negedge clk);
    check("R7 iso released after edge 2", {31'd0, iso_freeze}, 32'd0);
    rd_check("R7 status open", 5'd0, 32'd2);
    wr(5'd4, 32'd0);
    rd_check("R10 ctrl readback zero", 5'd4, 32'd0);
  endtask

  task automatic t_freeze_ack();
    wr(5'd4, 32'd1);
    iso_ack = 1'b1;
    rd_check("R4 status before ack edge", 5'd0, 32'd2);
    check("R4 iso raised", {31'd0, iso_freeze}, 32'd1);
    @(negedge clk);
    iso_ack = 1'b0;
    rd_check("R4 status after ack edge", 5'd0, 32'd1);
    wr(5'd4, 32'd4);
    rd_check("R8 no error on clean release", 5'd8, 32'd0);
    repeat (2) @(negedge clk);
    rd_check("R7 open after ack cycle", 5'd0, 32'd2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_map();
    t_readonly();
    t_illegal_open();
    t_freeze_timeout();
    t_sealed_ops();
    t_release();
    t_freeze_ack();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule